// File: doc/BRIEF.md
# Programmable Baud Clock Divider

This block divides a reference clock by a 16-bit divisor to produce the 16x oversampling clock used by a serial transmitter. A receiver may run from the same clock. Software reaches the divisor through a small register write port. One select bit chooses the low byte or the high byte.

The divided output is a clock-like waveform, and its shape depends on the divisor. A divisor of 1 hands the reference through untouched. A divisor of 2 or 3 gives a one-cycle low phase. Any larger divisor gives a two-cycle low phase followed by a long high phase. A divisor of 0 stops the generator with the output parked high.

A one-cycle tick marks the start of every output period, for logic clocked by the reference. A divisor change never cuts an output period short. The new value takes over at the next period boundary.

Top module: `baud_gen`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into the low divisor byte when `wr_sel` is 0, and into the high byte when `wr_sel` is 1. The divisor is {high, low}.
- R2: With a divisor of 1, `baud_out` equals the reference clock: high while `clk` is high and low while it is low.
- R3: With a divisor N of 2 or more, `baud_tick` pulses are exactly N reference cycles apart.
- R4: With N greater than 3, each period holds `baud_out` low for 2 cycles and then high for N-2 cycles. The tick coincides with the first low cycle.
- R5: With N of 2, the output is low 1 cycle and high 1 cycle. With N of 3, it is low 1 cycle and high 2 cycles. In both cases the tick falls on the low cycle.
- R6: With a divisor of 0, `baud_out` stays high and `baud_tick` stays low.
- R7: A divisor write lets the running period finish at its old length, and the new length applies from the following period. When the generator is stopped, a nonzero divisor starts it: the first tick comes one cycle after the write is captured.
- R8: After reset, `baud_out` is high, `baud_tick` is low, and both divisor bytes are 0.
- R9: `baud_tick` is high for a single reference cycle per period. With a divisor of 1, it is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Divisor byte write strobe |
| wr_sel | input | 1 | Byte select: 0 low byte, 1 high byte |
| wr_data | input | 8 | Byte to store |
| baud_out | output | 1 | Divided clock-like output |
| baud_tick | output | 1 | One-cycle pulse at the start of each period |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor split into two 8-bit bytes, and a two-cycle long low phase. This keeps a high-byte divisor of 261 within reach, so the high byte is shown to count. The bench also covers the special waveforms for divisors 1, 2 and 3, the general shape for 4, 5 and 6, and the stopped state at 0. Divisor changes are made mid-period to show the boundary reload, and starting from the stopped state shows the one-cycle start latency.

// File: rtl/baud_gen_pkg.sv
// Package: shared definitions for the baud clock divider.
// Assumes: the divisor width is a whole number of register bytes.
package baud_gen_pkg;

    // Output phase that the shaper drives in the next cycle.
    typedef enum logic [1:0] {
        PH_STOP   = 2'd0,   // divisor 0: output parked high, no tick
        PH_BYPASS = 2'd1,   // divisor 1: reference passed straight through
        PH_LOW    = 2'd2,   // low phase at the start of a period
        PH_HIGH   = 2'd3    // remaining high phase of a period
    } phase_e;

    // Default register byte width.
    localparam int unsigned BYTE_W_DEF = 8;

endpackage

// File: rtl/baud_divreg.sv
// Module: baud_divreg
// Holds the programmed divisor as a set of byte-wide registers written
// through a simple strobe/select/data port.
// Assumes: DIV_W is a multiple of BYTE_W; the select value picks byte
// index (0 = least significant). Writes to unused select values are ignored.
module baud_divreg #(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned NBYTE = DIV_W / BYTE_W,
    localparam int unsigned SEL_W = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [DIV_W-1:0]  div_value
);

    logic [BYTE_W-1:0] byte_q [NBYTE];

    genvar gi;
    generate
        for (gi = 0; gi < NBYTE; gi++) begin : g_byte
            // Store one divisor byte when it is selected.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    byte_q[gi] <= '0;
                end else if (wr_en && (wr_sel == SEL_W'(gi))) begin
                    byte_q[gi] <= wr_data;
                end
            end
            assign div_value[gi*BYTE_W +: BYTE_W] = byte_q[gi];
        end
    endgenerate

endmodule

// File: rtl/baud_counter.sv
// Module: baud_counter
// Keeps the divisor in force for the running period and the position
// inside that period. The programmed divisor is sampled only at a period
// boundary, or on any cycle while the generator is stopped.
// Assumes: position runs 0 .. active-1; exports next-state values so the
// shaper can register its outputs in step with the counter.
module baud_counter #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_value,
    output logic [DIV_W-1:0] act_div,
    output logic [DIV_W-1:0] pos,
    output logic [DIV_W-1:0] nxt_div,
    output logic [DIV_W-1:0] nxt_pos
);

    localparam logic [DIV_W-1:0] ZERO = '0;
    localparam logic [DIV_W-1:0] ONE  = DIV_W'(1);

    logic stopped;
    logic last_cycle;
    logic boundary;

    // Find the end of the running period or the stopped state.
    always_comb begin
        stopped    = (act_div == ZERO);
        last_cycle = !stopped && (pos == (act_div - ONE));
        boundary   = stopped || last_cycle;
    end

    // Choose the divisor and position for the next cycle.
    always_comb begin
        if (boundary) begin
            nxt_div = div_value;
            nxt_pos = ZERO;
        end else begin
            nxt_div = act_div;
            nxt_pos = pos + ONE;
        end
    end

    // Advance the active divisor and position registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_div <= ZERO;
            pos     <= ZERO;
        end else begin
            act_div <= nxt_div;
            pos     <= nxt_pos;
        end
    end

endmodule

// File: rtl/baud_shaper.sv
// Module: baud_shaper
// Turns the counter's next divisor and position into a registered output
// level and a registered start-of-period tick.
// Assumes: divisors above 3 use a LOW_CYCLES low phase; 2 and 3 use a
// one-cycle low phase; 1 is bypassed at the top; 0 parks the output high.
module baud_shaper
    import baud_gen_pkg::*;
#(
    parameter int unsigned DIV_W      = 16,
    parameter int unsigned LOW_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] nxt_div,
    input  logic [DIV_W-1:0] nxt_pos,
    output logic             shaped_q,
    output logic             tick_q
);

    localparam logic [DIV_W-1:0] LONG_LOW  = DIV_W'(LOW_CYCLES);
    localparam logic [DIV_W-1:0] SHORT_LOW = DIV_W'(1);
    localparam logic [DIV_W-1:0] SHORT_MAX = DIV_W'(3);

    phase_e           phase;
    logic [DIV_W-1:0] low_len;

    // Pick the low-phase length for the divisor in force next cycle.
    always_comb begin
        low_len = (nxt_div > SHORT_MAX) ? LONG_LOW : SHORT_LOW;
    end

    // Classify the next cycle into an output phase.
    always_comb begin
        if (nxt_div == '0) begin
            phase = PH_STOP;
        end else if (nxt_div == DIV_W'(1)) begin
            phase = PH_BYPASS;
        end else if (nxt_pos < low_len) begin
            phase = PH_LOW;
        end else begin
            phase = PH_HIGH;
        end
    end

    // Register the output level and the start-of-period tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shaped_q <= 1'b1;
            tick_q   <= 1'b0;
        end else begin
            shaped_q <= (phase != PH_LOW);
            tick_q   <= (phase != PH_STOP) && (nxt_pos == '0);
        end
    end

endmodule

// File: rtl/baud_gen.sv
// Module: baud_gen
// Programmable baud clock divider: byte-written divisor, boundary reload,
// divided output and a one-cycle tick per output period.
// Assumes: clk is the reference clock; a divisor of 1 routes clk itself
// to baud_out, so consumers must treat baud_out as a clock in that case.
module baud_gen #(
    parameter int unsigned DIV_W      = 16,
    parameter int unsigned BYTE_W     = baud_gen_pkg::BYTE_W_DEF,
    parameter int unsigned LOW_CYCLES = 2,
    localparam int unsigned NBYTE     = DIV_W / BYTE_W,
    localparam int unsigned SEL_W     = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              baud_out,
    output logic              baud_tick
);

    logic [DIV_W-1:0] div_value;
    logic [DIV_W-1:0] act_div_q;
    logic [DIV_W-1:0] pos_q;
    logic [DIV_W-1:0] nxt_div;
    logic [DIV_W-1:0] nxt_pos;
    logic             shaped_q;
    logic             tick_q;
    logic             bypass;

    baud_divreg #(
        .DIV_W (DIV_W),
        .BYTE_W(BYTE_W)
    ) u_divreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .div_value(div_value)
    );

    baud_counter #(
        .DIV_W(DIV_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_value(div_value),
        .act_div  (act_div_q),
        .pos      (pos_q),
        .nxt_div  (nxt_div),
        .nxt_pos  (nxt_pos)
    );

    baud_shaper #(
        .DIV_W     (DIV_W),
        .LOW_CYCLES(LOW_CYCLES)
    ) u_shaper (
        .clk     (clk),
        .rst_n   (rst_n),
        .nxt_div (nxt_div),
        .nxt_pos (nxt_pos),
        .shaped_q(shaped_q),
        .tick_q  (tick_q)
    );

    // Select the reference itself for divide-by-one, else the shaped level.
    always_comb begin
        bypass    = (act_div_q == DIV_W'(1));
        baud_out  = bypass ? clk : shaped_q;
        baud_tick = tick_q;
    end

endmodule

// File: rtl/baud_gen_sva.sv
// Module: baud_gen_sva
// Checker for baud_gen, attached by bind. Watches the active divisor,
// period position, shaped level and tick.
// Assumes: signals are sampled on the reference clock, reset synchronous.
module baud_gen_sva #(
    parameter int unsigned DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] act_div,
    input logic [DIV_W-1:0] pos,
    input logic             shaped,
    input logic             tick
);

    // R6: a stopped generator never ticks and keeps its level high.
    p_stopped_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_div == '0) |-> (!tick && shaped));

    // R3: the position always stays inside the running period.
    p_pos_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_div != '0) |-> (pos < act_div));

    // R4: for long divisors the cycle after a tick is still low.
    p_second_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (act_div > DIV_W'(3))) |=> !shaped);

    // R7: the active divisor only changes at a period boundary.
    p_reload_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_div != '0) && (pos != (act_div - DIV_W'(1)))) |=> $stable(act_div));

    // R9: a tick marks position zero of a running period.
    p_tick_at_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ((pos == '0) && (act_div != '0)));

endmodule

bind baud_gen baud_gen_sva #(.DIV_W(DIV_W)) u_sva (
    .clk    (clk),
    .rst_n  (rst_n),
    .act_div(act_div_q),
    .pos    (pos_q),
    .shaped (shaped_q),
    .tick   (tick_q)
);

// File: tb/baud_gen_test.sv
module baud_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       baud_out;
    logic       baud_tick;

    int total = 0;
    int bad   = 0;

    baud_gen uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .baud_out (baud_out),
        .baud_tick(baud_tick)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Writes one byte; call right after a negedge, returns at the next negedge.
    task automatic write_byte(input bit sel, input logic [7:0] val);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = val;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!baud_tick);
    endtask

    task automatic set_div(input int unsigned v);
        @(negedge clk);
        write_byte(1'b0, v[7:0]);
        write_byte(1'b1, v[15:8]);
        repeat (3) wait_tick();
    endtask

    // Checks one full period shape and the spacing to the next tick (R3/R4/R5/R9).
    task automatic check_period(input int n, input string req);
        int low;
        int err_i;
        int err_v;
        low   = (n > 3) ? 2 : 1;
        err_i = -1;
        err_v = 0;
        wait_tick();
        if (baud_out !== 1'b0) begin err_i = 0; err_v = baud_out; end
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            if (err_i < 0 && (baud_out !== ((i < low) ? 1'b0 : 1'b1) || baud_tick !== 1'b0)) begin
                err_i = i;
                err_v = baud_out;
            end
        end
        @(negedge clk);
        if (err_i < 0 && baud_tick !== 1'b1) begin err_i = n; err_v = baud_tick; end
        check(err_i < 0, req, err_i, -1);
    endtask

    task automatic t_reset_r8();
        @(negedge clk);
        check(baud_out === 1'b1, "R8 out high after reset", baud_out, 1);
        check(baud_tick === 1'b0, "R8 tick low after reset", baud_tick, 0);
        repeat (5) @(negedge clk);
        check(baud_tick === 1'b0, "R8 divisor zero keeps tick low", baud_tick, 0);
    endtask

    task automatic t_start_r7();
        int k;
        write_byte(1'b0, 8'd5);
        k = 0;
        while (!baud_tick && k < 10) begin @(negedge clk); k++; end
        check(k == 1, "R7 start latency from stopped", k, 1);
    endtask

    task automatic t_shapes_r4_r5();
        check_period(5, "R4 divisor 5 shape");
        set_div(2);  check_period(2, "R5 divisor 2 shape");
        set_div(3);  check_period(3, "R5 divisor 3 shape");
        set_div(4);  check_period(4, "R4 divisor 4 shape");
        set_div(6);  check_period(6, "R3 divisor 6 period");
    endtask

    task automatic t_high_byte_r1();
        set_div(261);
        check_period(261, "R1 high byte divisor 261");
    endtask

    task automatic t_bypass_r2();
        int errs;
        set_div(1);
        errs = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #1;
            if (baud_out !== 1'b0 || baud_tick !== 1'b1) errs++;
            @(posedge clk); #1;
            if (baud_out !== 1'b1) errs++;
        end
        check(errs == 0, "R2 R9 divide by one follows clock", errs, 0);
    endtask

    task automatic t_reload_r7();
        int k;
        set_div(6);
        wait_tick();
        write_byte(1'b0, 8'd4);
        k = 1;
        while (!baud_tick && k < 20) begin @(negedge clk); k++; end
        check(k == 6, "R7 running period keeps old length", k, 6);
        k = 0;
        do begin @(negedge clk); k++; end while (!baud_tick && k < 20);
        check(k == 4, "R7 new length after boundary", k, 4);
    endtask

    task automatic t_stop_r6();
        int errs;
        @(negedge clk);
        write_byte(1'b0, 8'd0);
        repeat (10) @(negedge clk);
        errs = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (baud_out !== 1'b1 || baud_tick !== 1'b0) errs++;
        end
        check(errs == 0, "R6 divisor zero holds high", errs, 0);
    endtask

    task automatic t_restart_r7();
        int k;
        write_byte(1'b0, 8'd3);
        k = 0;
        while (!baud_tick && k < 10) begin @(negedge clk); k++; end
        check(k == 1, "R7 restart latency", k, 1);
        check_period(3, "R5 divisor 3 after restart");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_r8();
        t_start_r7();
        t_shapes_r4_r5();
        t_high_byte_r1();
        t_bypass_r2();
        t_reload_r7();
        t_stop_r6();
        t_restart_r7();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule